// File: doc/BRIEF.md
# Dual-Mode Converter Bus Controller

This block is the bus-side sequencer of a sampling 8-bit converter that hangs on a microprocessor bus. It has an active-low chip select, an active-low read strobe and a mode input. One pin is shared between two roles. With the mode low, it is an open-drain ready output that holds the processor in a wait state while a read-started conversion runs. With the mode high, it is a write strobe whose falling edge starts a conversion. The conversion engine is not part of the block. A result byte and an overflow bit arrive on inputs and are sampled in the cycle the conversion completes. All timing is counted in cycles of `clk_i`.

In write-read mode a time-out counter starts when the write strobe rises. When it expires, the result is latched and the interrupt falls. A processor that does not wait for the interrupt may drop the read strobe early, once a minimum delay has passed. That read ends the conversion at once, latches the result and drives the bus in the same step. After each completion a guard window of `GAP_CYC` cycles rejects new start requests. The data bus is modelled as a value plus an output-enable pair, and the shared pin as an input level plus a pull-down enable.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset, `int_no` is 1, `wr_rdy_pd_o` is 0, `db_oe_o` is 0 and `ofl_o` is 0.
- R2: With `mode_i`=0, the first clock edge that sees `cs_ni` and `rd_ni` both low, after either was high, starts a conversion. `wr_rdy_pd_o` is 1 from the next cycle on. Exactly `CONV_CYC` edges after the start edge, the result is latched, `int_no` goes to 0 and `wr_rdy_pd_o` returns to 0.
- R3: `db_oe_o` is 1 exactly when `cs_ni`=0, `rd_ni`=0 and a result has been latched since reset. `db_o` carries the last latched byte.
- R4: A rising edge on `cs_ni` or `rd_ni` sets `int_no` to 1 from the next cycle. If that edge falls in the completion cycle, the result is still latched but `int_no` stays 1.
- R5: With `mode_i`=1, a falling edge on `wr_rdy_ni` while `cs_ni`=0 starts a conversion. Exactly `TOUT_CYC` edges after the edge that sees `wr_rdy_ni` rise, the result is latched and `int_no` goes to 0.
- R6: In write-read mode, suppose `rd_ni` falls with `cs_ni`=0 at edge j after the write rise edge, where `BYP_CYC` <= j <= `TOUT_CYC`. The result is then latched and `int_no` goes to 0 at that edge, and the bus is enabled.
- R7: A read falling edge at j < `BYP_CYC` does not end the conversion. Completion still happens at the time-out.
- R8: A start request seen within `GAP_CYC` edges after a completion edge is ignored: no ready, no conversion, and the bus still shows the old result. A request at edge `GAP_CYC`+1 or later is accepted.
- R9: `ofl_o` is latched from `conv_ofl_i` in the same cycle as `db_o` is latched from `conv_data_i`, and at no other time.
- R10: In read mode, a rise of `cs_ni` or `rd_ni` before completion abandons the conversion. `wr_rdy_pd_o` returns to 0 and nothing is latched.
- R11: `wr_rdy_ni` edges start nothing while `mode_i`=0, or while `cs_ni`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 read mode, 1 write-read mode |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_rdy_ni | input | 1 | Level of the shared pin (write strobe in mode 1) |
| wr_rdy_pd_o | output | 1 | Pull-down enable of the shared pin (ready, mode 0) |
| int_no | output | 1 | Completion interrupt, active low |
| conv_data_i | input | DW | Result from the conversion engine |
| conv_ofl_i | input | 1 | Overflow from the conversion engine |
| db_o | output | DW | Latched result byte |
| db_oe_o | output | 1 | Data bus drive enable |
| ofl_o | output | 1 | Latched overflow flag |

## Verification
Completion and interrupt release can fall in the same cycle. The bench provokes this by raising the read strobe exactly on the completion edge of a read-mode conversion. It then checks that `int_no` stays high, and drops the read strobe inside the guard window to see the new byte on the bus without starting a conversion. The early-read bypass and the time-out can also coincide. Random bypass delays that cover j = `TOUT_CYC` are judged against a bench function that gives the completion edge.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RDCONV,
    ST_WRLOW,
    ST_WRTIME
  } ctrl_st_e;

  typedef struct packed {
    logic rd_start;
    logic cs_rise;
    logic rd_rise;
    logic rd_fall;
    logic wr_fall;
    logic wr_rise;
  } bus_ev_t;
endpackage

// File: rtl/adc_bus_edges.sv
module adc_bus_edges #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] prev_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_o[g] <= 1'b1;
      else         prev_o[g] <= lvl_i[g];
    end
  end
endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq
  import adc_bus_pkg::*;
#(
  parameter int CONV_CYC = 70,
  parameter int TOUT_CYC = 38,
  parameter int BYP_CYC  = 25,
  parameter int GAP_CYC  = 50
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    mode_i,
  input  logic    cs_ni,
  input  bus_ev_t ev_i,
  output logic    done_o,
  output logic    rdy_pd_o,
  output logic    busy_o,
  output logic    gap_o
);
  localparam int MAXC = (CONV_CYC > TOUT_CYC) ? CONV_CYC : TOUT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int GW   = $clog2(GAP_CYC + 1);

  ctrl_st_e        st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [GW-1:0]   gap_q, gap_d;
  logic            release_w, byp_ok;

  assign release_w = ev_i.cs_rise | ev_i.rd_rise;
  assign byp_ok    = ev_i.rd_fall & ~cs_ni & (cnt_q >= CW'(BYP_CYC));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_o = 1'b0;
    gap_d  = (gap_q != '0) ? gap_q - GW'(1) : '0;
    unique case (st_q)
      ST_IDLE: begin
        if (gap_q == '0) begin
          if (!mode_i && ev_i.rd_start) begin
            st_d  = ST_RDCONV;
            cnt_d = CW'(1);
          end else if (mode_i && ev_i.wr_fall && !cs_ni) begin
            st_d = ST_WRLOW;
          end
        end
      end
      ST_RDCONV: begin
        if (cnt_q == CW'(CONV_CYC)) begin
          done_o = 1'b1;
          st_d   = ST_IDLE;
        end else if (release_w) begin
          st_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_WRLOW: begin
        if (ev_i.wr_rise) begin
          st_d  = ST_WRTIME;
          cnt_d = CW'(1);
        end
      end
      ST_WRTIME: begin
        if (cnt_q == CW'(TOUT_CYC) || byp_ok) begin
          done_o = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (done_o) gap_d = GW'(GAP_CYC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      gap_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      gap_q <= gap_d;
    end
  end

  assign rdy_pd_o = (st_q == ST_RDCONV);
  assign busy_o   = (st_q != ST_IDLE);
  assign gap_o    = (gap_q != '0);
endmodule

// File: rtl/adc_bus_out.sv
module adc_bus_out #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          release_i,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic [DW-1:0] data_i,
  input  logic          ofl_i,
  output logic [DW-1:0] db_o,
  output logic          db_oe_o,
  output logic          ofl_o,
  output logic          int_no
);
  logic valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_o    <= '0;
      ofl_o   <= 1'b0;
      valid_q <= 1'b0;
    end else if (done_i) begin
      db_o    <= data_i;
      ofl_o   <= ofl_i;
      valid_q <= 1'b1;
    end
  end

  // release in the completion cycle keeps the interrupt inactive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    int_no <= 1'b1;
    else if (release_i)             int_no <= 1'b1;
    else if (done_i)                int_no <= 1'b0;
  end

  assign db_oe_o = valid_q & ~cs_ni & ~rd_ni;
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CONV_CYC = 70,
  parameter int TOUT_CYC = 38,
  parameter int BYP_CYC  = 25,
  parameter int GAP_CYC  = 50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_rdy_ni,
  output logic          wr_rdy_pd_o,
  output logic          int_no,
  input  logic [DW-1:0] conv_data_i,
  input  logic          conv_ofl_i,
  output logic [DW-1:0] db_o,
  output logic          db_oe_o,
  output logic          ofl_o
);
  logic [2:0] lvl, prev;
  bus_ev_t    ev;
  logic       done_w, busy_w, gap_w;

  assign lvl = {wr_rdy_ni, rd_ni, cs_ni};

  adc_bus_edges #(.N(3)) u_edges (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .prev_o (prev)
  );

  always_comb begin
    ev.cs_rise  = cs_ni & ~prev[0];
    ev.rd_rise  = rd_ni & ~prev[1];
    ev.rd_fall  = ~rd_ni & prev[1];
    ev.wr_rise  = wr_rdy_ni & ~prev[2];
    ev.wr_fall  = ~wr_rdy_ni & prev[2];
    ev.rd_start = ~cs_ni & ~rd_ni & (prev[0] | prev[1]);
  end

  adc_bus_seq #(
    .CONV_CYC (CONV_CYC),
    .TOUT_CYC (TOUT_CYC),
    .BYP_CYC  (BYP_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .cs_ni    (cs_ni),
    .ev_i     (ev),
    .done_o   (done_w),
    .rdy_pd_o (wr_rdy_pd_o),
    .busy_o   (busy_w),
    .gap_o    (gap_w)
  );

  adc_bus_out #(.DW(DW)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done_w),
    .release_i (ev.cs_rise | ev.rd_rise),
    .cs_ni     (cs_ni),
    .rd_ni     (rd_ni),
    .data_i    (conv_data_i),
    .ofl_i     (conv_ofl_i),
    .db_o      (db_o),
    .db_oe_o   (db_oe_o),
    .ofl_o     (ofl_o),
    .int_no    (int_no)
  );
endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_i,
  input logic          cs_ni,
  input logic          rd_ni,
  input logic          wr_rdy_pd_o,
  input logic          int_no,
  input logic [DW-1:0] db_o,
  input logic          ofl_o,
  input logic          done_w,
  input logic          busy_w,
  input logic          gap_w
);
  p_rdy_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_rdy_pd_o) |-> $past(!mode_i && !cs_ni && !rd_ni));

  p_int_no_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_no) |-> !wr_rdy_pd_o);

  p_int_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_ni) || $rose(rd_ni)) |=> int_no);

  p_gap_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_w && gap_w) |=> !busy_w);

  p_latch_on_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({db_o, ofl_o}) |-> $past(done_w));
endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/adc_bus_ctrl_tb.sv
module adc_bus_ctrl_tb;
  localparam int DW = 8, CONV = 70, TOUT = 38, BYP = 25, GAP = 50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [DW-1:0] cdata = '0;
  logic cofl = 1'b0;
  logic pd, int_n, oe, ofl;
  logic [DW-1:0] db;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_bus_ctrl #(.DW(DW), .CONV_CYC(CONV), .TOUT_CYC(TOUT), .BYP_CYC(BYP),
                 .GAP_CYC(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cs_ni(cs_n), .rd_ni(rd_n),
    .wr_rdy_ni(wr_n), .wr_rdy_pd_o(pd), .int_no(int_n), .conv_data_i(cdata),
    .conv_ofl_i(cofl), .db_o(db), .db_oe_o(oe), .ofl_o(ofl));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic nstep(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_wr(input bit use_rd, input int d);
    return (use_rd && d >= BYP && d <= TOUT) ? d : TOUT;
  endfunction

  task automatic rd_conv(input logic [DW-1:0] d, input logic o, input bit collide);
    mode = 0; cdata = d; cofl = o;
    cs_n = 0; rd_n = 0;
    nstep(1);
    chk("R2 ready", pd, 1);
    nstep(CONV - 1);
    chk("R2 int before", int_n, 1);
    if (collide) rd_n = 1;
    nstep(1);
    chk("R2 ready off", pd, 0);
    if (!collide) begin
      chk("R2 int low", int_n, 0);
      chk("R3 oe", oe, 1);
      chk("R3 data", db, d);
      chk("R9 ofl", ofl, o);
    end else begin
      chk("R4 collide int", int_n, 1);
      rd_n = 0;
      nstep(1);
      chk("R8 no restart", pd, 0);
      chk("R4 collide latched", db, d);
      chk("R9 collide ofl", ofl, o);
    end
    cs_n = 1; rd_n = 1;
    nstep(1);
    chk("R4 int released", int_n, 1);
    chk("R3 oe off", oe, 0);
    nstep(GAP + 2);
  endtask

  task automatic wr_conv(input logic [DW-1:0] d, input logic o, input int wlen,
                         input bit use_rd, input int dly);
    int e;
    string tag;
    e = exp_wr(use_rd, dly);
    tag = (use_rd && dly >= BYP && dly <= TOUT) ? "R6" :
          (use_rd && dly < BYP) ? "R7" : "R5";
    mode = 1; cdata = d; cofl = o;
    cs_n = 0; wr_n = 0;
    nstep(wlen);
    wr_n = 1;
    for (int k = 1; k <= e + 1; k++) begin
      nstep(1);
      if (k == e) chk({tag, " int before"}, int_n, 1);
      if (k == e + 1) begin
        chk({tag, " int low"}, int_n, 0);
        chk({tag, " data"}, db, d);
        chk("R9 ofl", ofl, o);
      end
      if (use_rd && k == dly) rd_n = 0;
    end
    rd_n = 0;
    nstep(1);
    chk("R3 oe", oe, 1);
    chk("R3 data", db, d);
    cs_n = 1; rd_n = 1;
    nstep(1);
    chk("R4 int released", int_n, 1);
    nstep(GAP + 2);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    nstep(3);
    rst_n = 1;
    nstep(1);
    chk("R1 int", int_n, 1);
    chk("R1 pd", pd, 0);
    chk("R1 oe", oe, 0);
    chk("R1 ofl", ofl, 0);
    cs_n = 0; rd_n = 0; mode = 1;
    nstep(1);
    chk("R3 oe before any result", oe, 0);
    cs_n = 1; rd_n = 1;
    nstep(1);

    rd_conv(8'hA5, 1'b1, 0);
    wr_conv(8'h3C, 1'b0, 4, 0, 0);
    wr_conv(8'h81, 1'b1, 3, 1, BYP);
    wr_conv(8'h7E, 1'b0, 2, 1, BYP - 1);
    wr_conv(8'h19, 1'b1, 2, 1, TOUT);

    // R8 guard window
    mode = 0; cdata = 8'hC3; cofl = 0;
    cs_n = 0; rd_n = 0;
    nstep(CONV + 1);
    chk("R2 int low", int_n, 0);
    cs_n = 1; rd_n = 1;
    cdata = 8'h55;
    nstep(GAP - 1);
    cs_n = 0; rd_n = 0;
    nstep(1);
    chk("R8 ignored", pd, 0);
    chk("R8 old data", db, 8'hC3);
    rd_n = 1;
    nstep(1);
    rd_n = 0;
    nstep(1);
    chk("R8 accepted", pd, 1);
    nstep(CONV);
    chk("R8 done", int_n, 0);
    chk("R8 data", db, 8'h55);
    cs_n = 1; rd_n = 1;
    nstep(GAP + 2);

    // R10 abort
    cdata = 8'hEE;
    cs_n = 0; rd_n = 0;
    nstep(10);
    cs_n = 1;
    nstep(1);
    chk("R10 ready off", pd, 0);
    nstep(CONV + 5);
    chk("R10 int", int_n, 1);
    cs_n = 0;
    nstep(1);
    chk("R10 old data", db, 8'h55);
    cs_n = 1; rd_n = 1;
    nstep(2);

    // R11 write pin ignored
    mode = 0; cs_n = 0;
    wr_n = 0; nstep(3); wr_n = 1;
    nstep(TOUT + 5);
    chk("R11 mode0 int", int_n, 1);
    chk("R11 mode0 pd", pd, 0);
    cs_n = 1; mode = 1;
    wr_n = 0; nstep(3); wr_n = 1;
    nstep(TOUT + 5);
    chk("R11 cs high int", int_n, 1);
    nstep(2);

    rd_conv(8'h42, 1'b1, 1);

    for (int i = 0; i < 40; i++) begin
      logic [DW-1:0] d;
      logic o;
      d = DW'($urandom);
      o = 1'($urandom);
      if ($urandom_range(0, 2) == 0) rd_conv(d, o, 0);
      else wr_conv(d, o, $urandom_range(1, 8), 1'($urandom),
                   $urandom_range(1, TOUT + 4));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule